// File: doc/BRIEF.md
# CAN Sleep and Wake Manager

This block decides when the clock of a CAN protocol module may be switched off while the host processor idles or powers down, and when that clock must come back. It watches the processor's idle and power-down requests, a software sleep-enable bit, a bus-activity flag from the protocol engine and the five CAN interrupt pending lines. From these it drives a clock-enable for the CAN module, a sleep-permitted status bit, an active-low idle signal that fans out to the sibling CAN blocks, and a wake request to the processor.

While the module sleeps, a level change on the raw receive pin is detected without a clock edge. In idle mode that detection turns the clock back on at once, so the incoming frame can be received. The processor is not woken; only a stored message (message-complete) or another pending CAN interrupt raises the wake request. In power-down mode the same edge starts a fixed delay. When the delay ends, the module is brought up in the same receive-only state. The capture flag is cleared through a synchronizer chain once clocks run. Sleep cannot be entered again until that chain has emptied.

Top module: `can_sleep_mgr`

## Requirements
- R1: After reset the clock-enable is 1, the idle signal is 1 (not idle) and the wake request is 0.
- R2: The sleep-permitted bit is 1 exactly when the busy flag is 0 and all five pending interrupt lines are 0; any single pending line clears it.
- R3: While the sleep-enable bit is 0, an idle or power-down request leaves the clock-enable at 1.
- R4: With sleep-enable 1, a request present and sleep permitted, the clock-enable and the idle signal are both 0 from the next clock edge on.
- R5: The idle signal is 0 only while the sleep-permitted bit is 1; it returns to 1 in the same cycle that permission drops.
- R6: If sleep permission drops while the module is asleep, the clock-enable is 1 after the next clock edge.
- R7: In idle mode, a level change on the receive pin while asleep sets the clock-enable to 1 without waiting for a clock edge and does not raise the wake request.
- R8: After a receive-pin wake, the wake request pulses for exactly one cycle, one edge after message-complete or any pending interrupt is seen, and not before.
- R9: In power-down mode, a receive-pin change while asleep keeps the clock-enable at 0 for PD_DELAY cycles after the first edge that follows it (default 9892), then sets it to 1.
- R10: The receive capture flag clears through a two-stage synchronizer once clocks run; sleep is re-entered only after the flag and both stages are clear (at the seventh edge after the wake edge when message-complete arrives at the third).
- R11: The power-down delay counter restarts from zero on every new power-down wake; an interrupted count does not shorten the next one.
- R12: When the processor withdraws both requests while the module sleeps, the clock-enable is 1 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_idle_req | input | 1 | Processor is entering or in idle mode |
| cpu_pd_req | input | 1 | Processor is entering or in power-down mode (takes priority over idle) |
| sleep_en | input | 1 | Software sleep-enable control bit |
| can_busy | input | 1 | CAN bus activity in progress |
| irq_pend | input | 5 | Pending CAN interrupts: rx complete, tx complete, message error, frame error, rx buffer full |
| can_rx | input | 1 | Raw CAN receive pin |
| msg_done | input | 1 | Message-complete interrupt |
| can_clk_en | output | 1 | Clock-enable for the CAN module |
| sleep_ok | output | 1 | Sleep-permitted status bit |
| can_idle_n | output | 1 | Active-low idle signal to sibling CAN blocks |
| cpu_wake | output | 1 | Wake request to the processor |

## Verification
The bench checks the receive-pin wake in idle mode twice. It samples the clock-enable one time unit after the pin moves, with no clock edge in between, so a design that waits for a clock edge fails. It also checks that no wake request appears until message-complete, so a design that treats the pin edge as an interrupt fails. For power-down it counts the full 9892-cycle hold on both sides of the release edge, which exposes an off-by-one in the delay. It interrupts one count part way and repeats it, which exposes a counter that resumes instead of restarting. It checks that sleep is not re-entered while the synchronizer chain is still draining and that it is re-entered on the exact edge after it drains. It drops permission while asleep and checks that the idle signal rises in the same cycle and the clock returns one edge later.

// File: rtl/can_slp_pkg.sv
package can_slp_pkg;
   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_ASLEEP = 2'd1,
      ST_PDWAIT = 2'd2,
      ST_RXWAKE = 2'd3
   } slp_st_e;
endpackage

// File: rtl/can_slp_status.sv
module can_slp_status #(
   parameter int NUM_IRQ = 5
) (
   input  logic               bus_busy,
   input  logic [NUM_IRQ-1:0] pend,
   output logic               permit
);
   generate
      if (NUM_IRQ < 1) begin : g_bad_irq
         $error("NUM_IRQ must be at least 1");
      end
   endgenerate

   assign permit = ~bus_busy & ~(|pend);
endmodule

// File: rtl/can_rx_wake_latch.sv
module can_rx_wake_latch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic clr_ok,
   input  logic rx_pin,
   output logic rx_edge,
   output logic latch_busy
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                   rx_ref;
   logic                   flag;
   logic [SYNC_STAGES-1:0] chain;

   // reference level follows the pin until armed, then holds
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rx_ref <= 1'b1;
      else if (!arm) rx_ref <= rx_pin;
   end

   // clockless detection: any departure from the held level
   assign rx_edge = arm & (rx_pin != rx_ref);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              flag <= 1'b0;
      else if (rx_edge)                        flag <= 1'b1;
      else if (chain[SYNC_STAGES-1] && clr_ok) flag <= 1'b0;
   end

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= flag;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign latch_busy = flag | (|chain);

   // R10
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chain[SYNC_STAGES-1] && clr_ok && !rx_edge) |=> !flag);
endmodule

// File: rtl/can_pd_wake_timer.sv
module can_pd_wake_timer #(
   parameter int PD_DELAY = 9892
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   generate
      if (PD_DELAY < 2) begin : g_bad_dly
         $error("PD_DELAY must be at least 2");
      end
   endgenerate

   localparam int CNT_W = $clog2(PD_DELAY + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PD_DELAY - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run)        cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign done = run && (cnt == LAST);

   // R11
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

   // R9
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
endmodule

// File: rtl/can_sleep_mgr.sv
module can_sleep_mgr
   import can_slp_pkg::*;
#(
   parameter int NUM_IRQ     = 5,
   parameter int PD_DELAY    = 9892,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_idle_req,
   input  logic               cpu_pd_req,
   input  logic               sleep_en,
   input  logic               can_busy,
   input  logic [NUM_IRQ-1:0] irq_pend,
   input  logic               can_rx,
   input  logic               msg_done,
   output logic               can_clk_en,
   output logic               sleep_ok,
   output logic               can_idle_n,
   output logic               cpu_wake
);
   slp_st_e st, st_nxt;
   logic    rx_edge, latch_busy, pd_done;
   logic    want_sleep, wake_src;

   can_slp_status #(.NUM_IRQ(NUM_IRQ)) u_status (
      .bus_busy (can_busy),
      .pend     (irq_pend),
      .permit   (sleep_ok)
   );

   can_rx_wake_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (st == ST_ASLEEP),
      .clr_ok     ((st == ST_RUN) || (st == ST_RXWAKE)),
      .rx_pin     (can_rx),
      .rx_edge    (rx_edge),
      .latch_busy (latch_busy)
   );

   can_pd_wake_timer #(.PD_DELAY(PD_DELAY)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st == ST_PDWAIT),
      .done  (pd_done)
   );

   assign want_sleep = cpu_idle_req | cpu_pd_req;
   assign wake_src   = msg_done | (|irq_pend);

   always_comb begin
      st_nxt = st;
      unique case (st)
         ST_RUN:
            if (want_sleep && sleep_en && sleep_ok && !latch_busy)
               st_nxt = ST_ASLEEP;
         ST_ASLEEP:
            if (rx_edge)                       st_nxt = cpu_pd_req ? ST_PDWAIT : ST_RXWAKE;
            else if (!sleep_ok || !want_sleep) st_nxt = ST_RUN;
         ST_PDWAIT:
            if (!sleep_ok || !want_sleep)      st_nxt = ST_RUN;
            else if (pd_done)                  st_nxt = ST_RXWAKE;
         ST_RXWAKE:
            if (wake_src || !want_sleep)       st_nxt = ST_RUN;
         default:                              st_nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_RUN;
         cpu_wake <= 1'b0;
      end else begin
         st       <= st_nxt;
         cpu_wake <= (st == ST_RXWAKE) && wake_src;
      end
   end

   assign can_clk_en = (st == ST_RUN) || (st == ST_RXWAKE) ||
                       ((st == ST_ASLEEP) && rx_edge && !cpu_pd_req);

   assign can_idle_n = !((((st == ST_ASLEEP) && !rx_edge) || (st == ST_PDWAIT)) && sleep_ok);

   // R5
   idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !can_idle_n |-> sleep_ok);

   // R6
   drop_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_ASLEEP) && !sleep_ok) |=> can_clk_en);

   // R7
   rx_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ASLEEP) |=> !cpu_wake);

   // R9
   pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PDWAIT) |-> !can_clk_en);

   // R3
   no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_en && (st == ST_RUN)) |=> can_clk_en);

   // R8
   wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wake |=> !cpu_wake);
endmodule

// File: tb/sim_can_sleep_mgr.sv
module sim_can_sleep_mgr;
   localparam int CLK_P    = 10;
   localparam int PD_DELAY = 9892;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_idle_req = 1'b0, cpu_pd_req = 1'b0, sleep_en = 1'b0;
   logic       can_busy = 1'b0, can_rx = 1'b1, msg_done = 1'b0;
   logic [4:0] irq_pend = '0;
   logic       can_clk_en, sleep_ok, can_idle_n, cpu_wake;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   can_sleep_mgr #(.NUM_IRQ(5), .PD_DELAY(PD_DELAY), .SYNC_STAGES(2)) u0 (
      .clk, .rst_n, .cpu_idle_req, .cpu_pd_req, .sleep_en, .can_busy,
      .irq_pend, .can_rx, .msg_done, .can_clk_en, .sleep_ok, .can_idle_n,
      .cpu_wake
   );

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic quiesce();
      cpu_idle_req = 0; cpu_pd_req = 0; sleep_en = 0;
      can_busy = 0; irq_pend = '0; msg_done = 0;
      step(8);
   endtask

   task automatic t_reset();
      step(2);
      chk("R1 clk_en", can_clk_en, 1'b1);
      chk("R1 idle_n", can_idle_n, 1'b1);
      chk("R1 wake",   cpu_wake,   1'b0);
      rst_n = 1'b1;
      step(2);
      chk("R1 clk_en after release", can_clk_en, 1'b1);
   endtask

   task automatic t_status();
      can_busy = 0; irq_pend = '0; #1;
      chk("R2 idle bus", sleep_ok, 1'b1);
      can_busy = 1; #1;
      chk("R2 busy", sleep_ok, 1'b0);
      can_busy = 0;
      for (int i = 0; i < 5; i++) begin
         irq_pend = 5'(1 << i); #1;
         chk("R2 single pending", sleep_ok, 1'b0);
      end
      irq_pend = '0; #1;
      chk("R2 cleared", sleep_ok, 1'b1);
      step(1);
   endtask

   task automatic t_no_enable();
      quiesce();
      cpu_idle_req = 1; step(3);
      chk("R3 idle no enable", can_clk_en, 1'b1);
      cpu_idle_req = 0; cpu_pd_req = 1; step(3);
      chk("R3 pd no enable", can_clk_en, 1'b1);
   endtask

   task automatic t_enter_and_drop();
      quiesce();
      sleep_en = 1; cpu_idle_req = 1; #1;
      chk("R4 before edge", can_clk_en, 1'b1);
      step(1);
      chk("R4 clk_en off", can_clk_en, 1'b0);
      chk("R4 idle_n low", can_idle_n, 1'b0);
      can_busy = 1; #1;
      chk("R5 idle_n rises with permission", can_idle_n, 1'b1);
      chk("R6 same cycle still off", can_clk_en, 1'b0);
      step(1);
      chk("R6 clk_en back", can_clk_en, 1'b1);
      sleep_en = 0; can_busy = 0;
   endtask

   task automatic t_rx_idle_wake();
      quiesce();
      sleep_en = 1; cpu_idle_req = 1; step(1);
      chk("R4 asleep", can_clk_en, 1'b0);
      can_rx = ~can_rx; #1;
      chk("R7 immediate clk_en", can_clk_en, 1'b1);
      step(1);                       // edge 1
      chk("R7 no wake", cpu_wake, 1'b0);
      chk("R7 clocks stay on", can_clk_en, 1'b1);
      step(1);                       // edge 2
      chk("R8 no wake before msg", cpu_wake, 1'b0);
      msg_done = 1;
      step(1);                       // edge 3
      msg_done = 0;
      chk("R8 wake pulse", cpu_wake, 1'b1);
      step(1);                       // edge 4
      chk("R8 pulse one cycle", cpu_wake, 1'b0);
      chk("R10 no re-sleep while draining", can_clk_en, 1'b1);
      step(2);                       // edge 6
      chk("R10 still draining", can_clk_en, 1'b1);
      step(1);                       // edge 7
      chk("R10 re-sleep after drain", can_clk_en, 1'b0);
      cpu_idle_req = 0; step(1);
      chk("R12 leave on withdraw", can_clk_en, 1'b1);
   endtask

   task automatic t_rx_irq_wake();
      quiesce();
      sleep_en = 1; cpu_idle_req = 1; step(1);
      can_rx = ~can_rx; step(2);
      chk("R8 quiet before irq", cpu_wake, 1'b0);
      irq_pend = 5'b01000;
      step(1);
      chk("R8 wake on pending irq", cpu_wake, 1'b1);
      irq_pend = '0;
   endtask

   task automatic t_pd_wake();
      quiesce();
      sleep_en = 1; cpu_pd_req = 1; step(1);
      chk("R4 pd asleep", can_clk_en, 1'b0);
      can_rx = ~can_rx; #1;
      chk("R9 no immediate clock", can_clk_en, 1'b0);
      step(1);                       // E0
      chk("R9 hold start", can_clk_en, 1'b0);
      chk("R9 idle_n low in wait", can_idle_n, 1'b0);
      step(PD_DELAY - 1);
      chk("R9 hold last cycle", can_clk_en, 1'b0);
      step(1);
      chk("R9 release", can_clk_en, 1'b1);
      chk("R9 no wake yet", cpu_wake, 1'b0);
      msg_done = 1; step(1); msg_done = 0;
      chk("R8 pd path wake", cpu_wake, 1'b1);
   endtask

   task automatic t_pd_restart();
      quiesce();
      sleep_en = 1; cpu_pd_req = 1; step(1);
      can_rx = ~can_rx; step(1);     // PDWAIT
      step(100);
      cpu_pd_req = 0; step(1);
      chk("R12 leave pd wait", can_clk_en, 1'b1);
      step(8);
      cpu_pd_req = 1; step(1);
      chk("R11 re-asleep", can_clk_en, 1'b0);
      can_rx = ~can_rx; step(1);     // E0
      step(PD_DELAY - 1);
      chk("R11 full hold again", can_clk_en, 1'b0);
      step(1);
      chk("R11 release after full delay", can_clk_en, 1'b1);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_status();
      t_no_enable();
      t_enter_and_drop();
      t_rx_idle_wake();
      t_rx_irq_wake();
      t_pd_wake();
      t_pd_restart();
      quiesce();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule